// File: doc/BRIEF.md
# Serial Acknowledge Priority Chain

This block resolves simultaneous interrupt requests from a row of device cells by position rather than by an encoder. All cell requests are merged into one interrupt line toward the processor. When the processor answers with its acknowledge, that acknowledge enters the first cell as its priority input. A cell with a request pending keeps the grant. A cell with nothing pending hands the acknowledge on to the next cell. The cell that keeps the grant places its own vector on the shared data bus.

The acknowledge ripples through every cell ahead of the winner, so the resolution path grows linearly with the chain length. The chain length and the vector width are parameters. Each cell's vector is an entry of a packed parameter array. All outputs are registered: they follow the inputs of the previous clock edge. Reset is synchronous and active high.

Top module: `irq_chain`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge, whatever the inputs are.
- R2: `irq_o` after each edge equals the OR of all bits of `req_i` sampled at that edge.
- R3: If `ack_i` is low at an edge, then after it `grant_o` is all zeros, `bus_o` is zero and `bus_valid_o` is low.
- R4: If `ack_i` is high at an edge and some request is pending, then after it `grant_o` is one-hot at the lowest-indexed pending cell. Cell 0 sits first in the chain and has the highest priority.
- R5: When a cell wins, `bus_valid_o` is high and `bus_o` carries that cell's vector. The default vector of cell k is 8'h40 + 4*k.
- R6: If `ack_i` is high and no request is pending, then `grant_o` is zero, `bus_o` is zero and `bus_valid_o` is low. `chain_out_o` is high because the acknowledge passed through every cell.
- R7: `grant_o` never has more than one bit set.
- R8: A winning cell drives its priority output low. So `chain_out_o` is low whenever `bus_valid_o` is high, and it is high only when the acknowledge passed every cell.
- R9: Requests from cells after the winner have no effect on `bus_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_CELLS | Per-cell request lines, bit 0 = first cell |
| ack_i | input | 1 | Processor acknowledge, feeds the first cell's priority input |
| irq_o | output | 1 | Merged interrupt request to the processor |
| grant_o | output | N_CELLS | One-hot grant visibility |
| bus_o | output | VEC_W | Shared data bus carrying the winner's vector, zero when idle |
| bus_valid_o | output | 1 | High when some cell drives the bus |
| chain_out_o | output | 1 | Priority output of the last cell |

## Verification
The hardest case to reach from the ports is a winner deep in the chain while later cells are also requesting. In that case the acknowledge has to pass several idle cells and then be blocked, and the bus must show only the winner's vector. The stimulus sweeps every request pattern of the chain with acknowledge high, and so reaches each winner position with every combination of losing requesters behind it. Patterns with acknowledge low and an empty request set are mixed in, so that the blocked, passed-through and idle paths are each seen at the chain end.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef enum logic [1:0] {
    CELL_IDLE = 2'd0,
    CELL_PASS = 2'd1,
    CELL_HOLD = 2'd2
  } cell_mode_e;
endpackage

// File: rtl/irq_cell.sv
module irq_cell
  import irq_chain_pkg::*;
(
  input  logic       pi,
  input  logic       req,
  output logic       po,
  output logic       hold,
  output cell_mode_e mode
);
  always_comb begin
    mode = CELL_IDLE;
    if (pi) mode = req ? CELL_HOLD : CELL_PASS;
  end

  assign hold = (mode == CELL_HOLD);
  assign po   = (mode == CELL_PASS);
endmodule

// File: rtl/irq_bus_mux.sv
module irq_bus_mux #(
  parameter int N_CELLS = 6,
  parameter int VEC_W   = 8,
  parameter logic [N_CELLS*VEC_W-1:0] VECTORS = '0
) (
  input  logic [N_CELLS-1:0] grant,
  output logic [VEC_W-1:0]   bus,
  output logic               valid
);
  logic [VEC_W-1:0] term [N_CELLS];
  logic [VEC_W-1:0] acc  [N_CELLS+1];

  assign acc[0] = '0;
  for (genvar k = 0; k < N_CELLS; k++) begin : g_term
    assign term[k]  = grant[k] ? VECTORS[k*VEC_W +: VEC_W] : '0;
    assign acc[k+1] = acc[k] | term[k];
  end

  assign bus   = acc[N_CELLS];
  assign valid = |grant;
endmodule

// File: rtl/irq_chain.sv
module irq_chain
  import irq_chain_pkg::*;
#(
  parameter int N_CELLS = 6,
  parameter int VEC_W   = 8,
  parameter logic [N_CELLS*VEC_W-1:0] VECTORS =
    {8'h54, 8'h50, 8'h4C, 8'h48, 8'h44, 8'h40}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CELLS-1:0] req_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [N_CELLS-1:0] grant_o,
  output logic [VEC_W-1:0]   bus_o,
  output logic               bus_valid_o,
  output logic               chain_out_o
);
  logic [N_CELLS:0]   link;
  logic [N_CELLS-1:0] hold;
  cell_mode_e         mode [N_CELLS];
  logic [VEC_W-1:0]   bus_c;
  logic               valid_c;

  assign link[0] = ack_i;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    irq_cell u_cell (
      .pi   (link[k]),
      .req  (req_i[k]),
      .po   (link[k+1]),
      .hold (hold[k]),
      .mode (mode[k])
    );
  end

  irq_bus_mux #(
    .N_CELLS (N_CELLS),
    .VEC_W   (VEC_W),
    .VECTORS (VECTORS)
  ) u_mux (
    .grant (hold),
    .bus   (bus_c),
    .valid (valid_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      grant_o     <= '0;
      bus_o       <= '0;
      bus_valid_o <= 1'b0;
      chain_out_o <= 1'b0;
    end else begin
      irq_o       <= |req_i;
      grant_o     <= hold;
      bus_o       <= bus_c;
      bus_valid_o <= valid_c;
      chain_out_o <= link[N_CELLS];
    end
  end
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int N_CELLS = 6,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [N_CELLS-1:0] req_i,
  input logic               ack_i,
  input logic               irq_o,
  input logic [N_CELLS-1:0] grant_o,
  input logic [VEC_W-1:0]   bus_o,
  input logic               bus_valid_o,
  input logic               chain_out_o
);
  // R2
  a_r2_irq_merge: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |$past(req_i)));
  // R3
  a_r3_no_ack_idle: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> (grant_o == '0 && bus_o == '0 && !bus_valid_o));
  // R4
  a_r4_first_wins: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_i[0]) |=> grant_o[0]);
  // R7
  a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));
  // R8
  a_r8_blocked_tail: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o |-> !chain_out_o);
  // R6
  a_r6_pass_all: assert property (@(posedge clk) disable iff (rst)
    (ack_i && req_i == '0) |=> (chain_out_o && !bus_valid_o));
endmodule

bind irq_chain irq_chain_chk #(.N_CELLS(N_CELLS), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .ack_i(ack_i), .irq_o(irq_o),
  .grant_o(grant_o), .bus_o(bus_o), .bus_valid_o(bus_valid_o),
  .chain_out_o(chain_out_o)
);

// File: tb/irq_chain_test.sv
module irq_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req_i = '0;
  logic ack_i = 1'b0;
  logic irq_o, bus_valid_o, chain_out_o;
  logic [N-1:0] grant_o;
  logic [W-1:0] bus_o;

  int total = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [N-1:0] req;
    logic         ack;
    logic [N-1:0] grant;
    logic [W-1:0] bus;
    logic         valid;
    logic         irq;
    logic         tail;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_chain uut (
    .clk(clk), .rst(rst), .req_i(req_i), .ack_i(ack_i), .irq_o(irq_o),
    .grant_o(grant_o), .bus_o(bus_o), .bus_valid_o(bus_valid_o),
    .chain_out_o(chain_out_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [N-1:0] r, input logic a);
    exp_t e;
    e.req = r; e.ack = a; e.grant = '0; e.bus = '0; e.valid = 1'b0;
    e.irq = |r; e.tail = a;
    if (a) begin
      for (int k = 0; k < N; k++) begin
        if (r[k] && e.grant == '0) begin
          e.grant[k] = 1'b1;
          e.bus      = W'(8'h40 + 4 * k);
          e.valid    = 1'b1;
          e.tail     = 1'b0;
        end
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [N-1:0] r, input logic a);
    @(negedge clk);
    req_i = r;
    ack_i = a;
    q.push_back(model(r, a));
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t e;
        int ones;
        e = q.pop_front();
        check("R2 irq", irq_o, e.irq);
        if (!e.ack)          check("R3 grant", grant_o, e.grant);
        else if (e.req == 0) check("R6 grant", grant_o, e.grant);
        else                 check("R4 grant", grant_o, e.grant);
        if (e.valid && (e.req & ~((e.grant << 1) - 1)) != 0)
          check("R9 bus", bus_o, e.bus);
        else
          check("R5 bus", bus_o, e.bus);
        check("R5 valid", bus_valid_o, e.valid);
        check("R8 tail", chain_out_o, e.tail);
        ones = $countones(grant_o);
        check("R7 onehot", ones <= 1, 1);
      end
    end
  end

  initial begin
    repeat (CLK_PERIOD * 0 + 3) @(negedge clk);
    req_i = '1; ack_i = 1'b1;
    @(negedge clk);
    check("R1 irq", irq_o, 0);
    check("R1 grant", grant_o, 0);
    check("R1 bus", bus_o, 0);
    check("R1 valid", bus_valid_o, 0);
    check("R1 tail", chain_out_o, 0);
    rst = 1'b0;
    drive('0, 1'b0);
    drive('0, 1'b1);
    drive(6'b111111, 1'b0);
    for (int p = 0; p < (1 << N); p++) drive(N'(p), 1'b1);
    for (int p = 0; p < (1 << N); p += 7) drive(N'(p), 1'b0);
    drive(6'b100000, 1'b1);
    drive(6'b000000, 1'b1);
    drive(6'b110100, 1'b1);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule